// File: doc/BRIEF.md
# Packed LED Matrix Row Scanner

This block drives an eight-line LED matrix one row at a time from a 32-bit frame. The frame holds four bytes in a packed triangular layout: one byte can carry the lit bits of two different rows. For each of the eight scan steps the block unpacks that row's bits from the frame. It merges them with a one-hot row-select bit and presents the result on an 8-bit drive bus. It holds each pattern for a programmable number of clock cycles and then moves to the next row.

The frame is captured only when a scan starts at row 0, so one pass over the matrix always shows a single, consistent frame. The line-enable bus is driven high on every line once scanning is under way. The current row index is exposed so that surrounding logic can follow the scan position. Mapping to physical pins, output polarity and any second scan channel belong outside this block.

Top module: `led_matrix_scanner`

## Requirements
- R1: While `rst` is high, and on the first clock edge at which `rst` is sampled high, `row_idx` is 0 and `line_drive` and `line_en` are all zeros. The reset is synchronous and active high.
- R2: On the first rising clock edge after `rst` is sampled low, the block loads row 0 and begins scanning.
- R3: Each row is held for exactly DWELL_CYCLES clock cycles. After that, `row_idx` increments by one.
- R4: After row 7 has been held, the scan wraps to row 0.
- R5: In every loaded row r, bit (7 - r) of `line_drive` is 1. This is the one-hot row select, the value 0x80 shifted right by r, ORed into the pattern.
- R6: Byte k of the frame is `frame[8k+7:8k]`. For rows r = 0 to 3, the data part of `line_drive` is byte r shifted right by r.
- R7: For rows r = 4 to 7, the data part of `line_drive` is byte (r - 4) ANDed with 0xFF shifted left by (r - 4).
- R8: From the first row load onward, `line_en` is 0xFF.
- R9: `frame` is sampled only on the clock edge that loads row 0. A change of `frame` during rows 1 to 7 has no effect on `line_drive` until the next scan starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame | input | 32 | Packed frame, four bytes |
| line_drive | output | 8 | Drive pattern for the current row |
| line_en | output | 8 | Line enables, all ones while scanning |
| row_idx | output | 3 | Index of the row currently shown |

## Verification
The assertions assume that `rst` is synchronous and stays high for at least one clock edge. They also assume that the parameter DWELL_CYCLES is at least 1. Each assertion relates the dwell counter, the row register and the captured frame only to the load strobe. For that reason they place no constraint on `frame`. The bench uses a dwell of three cycles and changes `frame` on falling edges at points that do not line up with the scan period. The captured-frame rule is therefore tested with changes inside rows as well as at scan boundaries.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
  localparam int ROWS    = 8;
  localparam int LINES   = 8;
  localparam int BYTES   = 4;
  localparam int FRAME_W = LINES * BYTES;
  localparam int ROW_W   = $clog2(ROWS);

  typedef logic [ROW_W-1:0]   row_t;
  typedef logic [LINES-1:0]   line_t;
  typedef logic [FRAME_W-1:0] frame_t;

  // One-hot row select for a given row
  function automatic line_t row_select(row_t r);
    return line_t'({1'b1, {(LINES-1){1'b0}}}) >> r;
  endfunction

  // Data bits for a row, taken from the triangular packing
  function automatic line_t row_data(frame_t f, row_t r);
    line_t b;
    logic [1:0] idx;
    idx = r[1:0];
    b = f[LINES*idx +: LINES];
    if (!r[2]) return b >> r;
    else       return b & (line_t'('1) << idx);
  endfunction

  function automatic line_t row_drive(frame_t f, row_t r);
    return row_select(r) | row_data(f, r);
  endfunction
endpackage

// File: rtl/scan_dwell_timer.sv
module scan_dwell_timer #(
  parameter int DWELL_CYCLES = 200000
) (
  input  logic clk,
  input  logic rst,
  output logic step,
  output logic first
);
  localparam int CNT_W = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             started;

  assign first = !started;
  assign step  = !started || (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      started <= 1'b0;
    end else begin
      started <= 1'b1;
      if (step) cnt <= '0;
      else      cnt <= cnt + 1'b1;
    end
  end

  // R3: the dwell counter stays inside its window
  assert_cnt_in_window_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // R2: the very first active cycle after reset produces a load
  assert_first_load_R2: assert property (@(posedge clk) disable iff (rst)
    first |-> step);
endmodule

// File: rtl/scan_row_sequencer.sv
module scan_row_sequencer
  import led_scan_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic first,
  output row_t row_q,
  output row_t row_next,
  output logic scan_start
);
  localparam row_t LAST_ROW = row_t'(ROWS - 1);

  always_comb begin
    if (first)                 row_next = '0;
    else if (row_q == LAST_ROW) row_next = '0;
    else                       row_next = row_q + 1'b1;
  end

  assign scan_start = step && (row_next == '0);

  always_ff @(posedge clk) begin
    if (rst)       row_q <= '0;
    else if (step) row_q <= row_next;
  end

  // R3: the row only moves on a load strobe
  assert_row_holds_R3: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(row_q));

  // R4: after the last row the scan returns to row 0
  assert_row_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (step && !first && row_q == LAST_ROW) |=> (row_q == '0));

  // R3: a normal step advances by exactly one
  assert_row_inc_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !first && row_q != LAST_ROW) |=> (row_q == $past(row_q) + 1'b1));
endmodule

// File: rtl/scan_pattern_unit.sv
module scan_pattern_unit
  import led_scan_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   step,
  input  logic   scan_start,
  input  row_t   row_next,
  input  frame_t frame_in,
  output line_t  drive_q,
  output line_t  en_q
);
  frame_t frame_q;
  frame_t frame_use;

  assign frame_use = scan_start ? frame_in : frame_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      drive_q <= '0;
      en_q    <= '0;
    end else begin
      if (scan_start) frame_q <= frame_in;
      if (step) begin
        drive_q <= row_drive(frame_use, row_next);
        en_q    <= '1;
      end
    end
  end

  // R9: the captured frame only changes when a scan starts
  assert_frame_held_R9: assert property (@(posedge clk) disable iff (rst)
    !scan_start |=> $stable(frame_q));

  // R8: enables stay all ones once any row has been loaded
  assert_en_on_R8: assert property (@(posedge clk) disable iff (rst)
    step |=> (en_q == '1));

  // R9: the pattern only changes on a load strobe
  assert_drive_held_R9: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(drive_q));
endmodule

// File: rtl/led_matrix_scanner.sv
module led_matrix_scanner
  import led_scan_pkg::*;
#(
  parameter int DWELL_CYCLES = 200000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FRAME_W-1:0] frame,
  output logic [LINES-1:0]   line_drive,
  output logic [LINES-1:0]   line_en,
  output logic [ROW_W-1:0]   row_idx
);
  logic step;
  logic first;
  logic scan_start;
  row_t row_q;
  row_t row_next;

  scan_dwell_timer #(.DWELL_CYCLES(DWELL_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .step  (step),
    .first (first)
  );

  scan_row_sequencer u_seq (
    .clk        (clk),
    .rst        (rst),
    .step       (step),
    .first      (first),
    .row_q      (row_q),
    .row_next   (row_next),
    .scan_start (scan_start)
  );

  scan_pattern_unit u_pat (
    .clk        (clk),
    .rst        (rst),
    .step       (step),
    .scan_start (scan_start),
    .row_next   (row_next),
    .frame_in   (frame),
    .drive_q    (line_drive),
    .en_q       (line_en)
  );

  assign row_idx = row_q;

  // R5: once running, the drive carries the select bit of the shown row
  assert_select_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (line_en == '1) |-> line_drive[(LINES-1) - int'(row_idx)]);

  // R1: a reset edge clears the outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (line_drive == '0 && line_en == '0 && row_idx == '0));
endmodule

// File: tb/led_matrix_scanner_tb.sv
module led_matrix_scanner_tb;
  localparam int DW   = 3;
  localparam int SCAN = 8 * DW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] frame = '0;
  logic [7:0]  line_drive;
  logic [7:0]  line_en;
  logic [2:0]  row_idx;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  led_matrix_scanner #(.DWELL_CYCLES(DW)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .frame      (frame),
    .line_drive (line_drive),
    .line_en    (line_en),
    .row_idx    (row_idx)
  );

  // Expected pattern built bit by bit from the packing rules
  function automatic logic [7:0] expect_drive(logic [31:0] f, int r);
    logic [7:0] v;
    v = '0;
    for (int j = 0; j < 8; j++) begin
      if (j == 7 - r) v[j] = 1'b1;
      if (r < 4) begin
        if (j + r < 8 && f[8*r + j + r]) v[j] = 1'b1;
      end else begin
        if (j >= r - 4 && f[8*(r-4) + j]) v[j] = 1'b1;
      end
    end
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_frame(int n);
    logic [31:0] x;
    if (n == 0)       x = 32'h0;
    else if (n == 1)  x = 32'hFFFF_FFFF;
    else if (n < 34)  x = 32'h1 << (n - 2);
    else              x = (32'h9E37_79B9 * n) ^ (32'h5A5A_A5A5 >> (n % 7));
    return x;
  endfunction

  // Run N cycles of scan, checking each one, changing frame off-period
  task automatic run_scan(int ncyc, int seed);
    logic [31:0] lat;
    int fidx;
    lat  = '0;
    fidx = seed;
    for (int k = 0; k < ncyc; k++) begin
      int r;
      @(posedge clk);
      if (k % SCAN == 0) lat = frame;
      @(negedge clk);
      r = (k / DW) % 8;
      if (k == 0) chk("R2 row", 32'(row_idx), 0);
      if ((k / DW) % 8 == 0 && k >= SCAN && k % DW == 0)
        chk("R4 wrap", 32'(row_idx), 0);
      else
        chk("R3 row", 32'(row_idx), 32'(r));
      chk("R8 en", 32'(line_en), 32'hFF);
      chk("R5 sel", 32'(line_drive[7-r]), 1);
      if (r < 4) chk("R6 drive", 32'(line_drive), 32'(expect_drive(lat, r)));
      else       chk("R7 drive", 32'(line_drive), 32'(expect_drive(lat, r)));
      if (k % SCAN != 0 && k % 7 == 3) chk("R9 drive", 32'(line_drive), 32'(expect_drive(lat, r)));
      if (k % 7 == 3) begin
        fidx++;
        frame = next_frame(fidx);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 row", 32'(row_idx), 0);
    chk("R1 drive", 32'(line_drive), 0);
    chk("R1 en", 32'(line_en), 0);
    frame = 32'hA5C3_0F81;
    rst = 1'b0;
    run_scan(SCAN * 30, 0);
    // reset in the middle of a scan
    rst = 1'b1;
    @(negedge clk);
    chk("R1 row mid", 32'(row_idx), 0);
    chk("R1 drive mid", 32'(line_drive), 0);
    chk("R1 en mid", 32'(line_en), 0);
    frame = 32'hFFFF_FFFF;
    rst = 1'b0;
    run_scan(SCAN * 12, 40);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule